// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which receive message buffers, and which entries of a receive FIFO filter table, accept an incoming CAN frame. Each candidate holds a configured identifier, IDE bit and RTR bit. For every candidate the block picks an acceptance mask and compares the received frame against it. A mask bit of one makes the matching bit compulsory and a zero makes it don't-care.

Three mode conditions drive the mask choice. With per-buffer masking off, every candidate uses the shared mask, except the last two buffers and the last two FIFO filter entries, which each use one of two dedicated masks. With per-buffer masking on, every candidate uses its own mask. Mask writes go through a small write port and land only while the freeze input is high. When the receive FIFO is on, the buffers it occupies drop out of the ordinary match result.

One cycle after a frame strobe the block registers its result: a valid pulse, then a hit vector, the lowest hit index and an empty flag for the buffers, and the same three for the FIFO table.

Top module: `can_accept_filter`

## Requirements
- R1: A candidate matches only when every identifier bit whose mask bit is 1 equals the received bit. Identifier bits whose mask bit is 0 never affect the result.
- R2: After reset every mask holds all ones in its 31 bits, so every identifier bit is compared exactly until a write changes it.
- R3: With per-buffer masking off, buffer NBUF-2 uses dedicated mask A, buffer NBUF-1 uses dedicated mask B, and every other buffer uses the shared mask.
- R4: With per-buffer masking on, buffer k and FIFO entry k use individual mask k. The shared mask and both dedicated masks then have no effect.
- R5: With the FIFO on and per-buffer masking off, FIFO entry NFIFO-2 uses dedicated mask A, entry NFIFO-1 uses dedicated mask B, and the other entries use the shared mask.
- R6: Mask layout: bits 28..0 cover identifier bits 28..0, bit 29 covers IDE and bit 30 covers RTR. These last two apply only to FIFO entries. An ordinary buffer needs an exact IDE match and ignores RTR.
- R7: A standard identifier sits in identifier bits 28..18. When the received IDE is 0, identifier bits 17..0 are ignored.
- R8: A write (select 0 shared, 1 mask A, 2 mask B, 3+k individual k) changes a mask only while freeze_i is high. A write while freeze_i is low has no effect.
- R9: While the FIFO is on, buffers 0..NFIFO-1 never appear in the buffer hit vector. While the FIFO is off, the FIFO hit vector is zero.
- R10: Results are registered on the clock edge that samples frame_vld_i high. res_vld_o is high for exactly the following cycle.
- R11: Each index output gives the lowest set bit of its hit vector. Each none flag is high exactly when its vector is zero. Reset leaves both none flags high and both vectors zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_i | input | 1 | Enables mask writes |
| wr_en_i | input | 1 | Mask write strobe |
| wr_sel_i | input | SELW | Mask select: 0 shared, 1 A, 2 B, 3+k individual |
| wr_data_i | input | 31 | Mask write value |
| indiv_en_i | input | 1 | Per-buffer masking enable |
| fifo_en_i | input | 1 | Receive FIFO enable |
| flt_id_i | input | NBUF*29 | Configured identifiers, buffer k at bits k*29 upward |
| flt_ide_i | input | NBUF | Configured IDE per buffer |
| flt_rtr_i | input | NBUF | Configured RTR per buffer |
| frame_vld_i | input | 1 | Received frame strobe |
| rx_id_i | input | 29 | Received identifier |
| rx_ide_i | input | 1 | Received IDE |
| rx_rtr_i | input | 1 | Received RTR |
| res_vld_o | output | 1 | Result valid pulse |
| buf_hit_o | output | NBUF | Buffer hit vector |
| buf_idx_o | output | BIW | Lowest hit buffer |
| buf_none_o | output | 1 | No buffer hit |
| fifo_hit_o | output | NFIFO | FIFO entry hit vector |
| fifo_idx_o | output | FIW | Lowest hit FIFO entry |
| fifo_none_o | output | 1 | No FIFO entry hit |

## Verification
The assertions assume that the mode inputs, the filter values and the received frame are stable at the edge that samples the strobe, and that freeze_i is a clean level at each write edge. The stimulus drives every input on the falling edge, so each frame sees one fixed set of masks and modes. Random masks and frames are biased so that many frames nearly match, with IDE flipped or a single identifier bit changed. Directed cases, with the last two entries singled out, exercise the dedicated masks.

// File: rtl/cafl_pkg.sv
package cafl_pkg;
  localparam int ID_W    = 29;
  localparam int STD_W   = 11;
  localparam int MASK_W  = ID_W + 2;
  localparam int MB_IDE  = ID_W;
  localparam int MB_RTR  = ID_W + 1;
  localparam int SEL_GLB = 0;
  localparam int SEL_LA  = 1;
  localparam int SEL_LB  = 2;
  localparam int SEL_IND = 3;

  typedef logic [MASK_W-1:0] mask_t;

  // identifier bits that take part for the given frame format
  function automatic logic [ID_W-1:0] id_care(input logic ide);
    return ide ? {ID_W{1'b1}} : {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};
  endfunction
endpackage

// File: rtl/cafl_mask_regs.sv
module cafl_mask_regs import cafl_pkg::*; #(
  parameter int NBUF = 16,
  parameter int SELW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            freeze_i,
  input  logic            wr_en_i,
  input  logic [SELW-1:0] wr_sel_i,
  input  mask_t           wr_data_i,
  output mask_t           glb_o,
  output mask_t           la_o,
  output mask_t           lb_o,
  output mask_t [NBUF-1:0] ind_o
);
  logic wr_ok;
  mask_t glb_q, la_q, lb_q;
  mask_t [NBUF-1:0] ind_q;

  assign wr_ok = wr_en_i & freeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q <= '1;
      la_q  <= '1;
      lb_q  <= '1;
    end else if (wr_ok) begin
      if (wr_sel_i == SELW'(SEL_GLB)) glb_q <= wr_data_i;
      if (wr_sel_i == SELW'(SEL_LA))  la_q  <= wr_data_i;
      if (wr_sel_i == SELW'(SEL_LB))  lb_q  <= wr_data_i;
    end
  end

  for (genvar k = 0; k < NBUF; k++) begin : g_ind
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ind_q[k] <= '1;
      else if (wr_ok && wr_sel_i == SELW'(SEL_IND + k)) ind_q[k] <= wr_data_i;
    end
  end

  assign glb_o = glb_q;
  assign la_o  = la_q;
  assign lb_o  = lb_q;
  assign ind_o = ind_q;

  // R8
  no_write_wo_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i |=> ($stable(glb_q) && $stable(la_q) && $stable(lb_q) && $stable(ind_q)));
endmodule

// File: rtl/cafl_cmp.sv
module cafl_cmp import cafl_pkg::*; (
  input  logic            fifo_i,
  input  logic [ID_W-1:0] rx_id_i,
  input  logic            rx_ide_i,
  input  logic            rx_rtr_i,
  input  logic [ID_W-1:0] flt_id_i,
  input  logic            flt_ide_i,
  input  logic            flt_rtr_i,
  input  mask_t           mask_i,
  output logic            hit_o
);
  logic [ID_W-1:0] care;
  logic id_ok, ide_ok, rtr_ok;

  assign care   = mask_i[ID_W-1:0] & id_care(rx_ide_i);
  assign id_ok  = ((rx_id_i ^ flt_id_i) & care) == '0;
  // ordinary buffers: IDE always exact, RTR ignored
  assign ide_ok = (fifo_i && !mask_i[MB_IDE]) || (rx_ide_i == flt_ide_i);
  assign rtr_ok = !fifo_i || !mask_i[MB_RTR] || (rx_rtr_i == flt_rtr_i);
  assign hit_o  = id_ok & ide_ok & rtr_ok;
endmodule

// File: rtl/cafl_lowest.sv
module cafl_lowest #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          none_o
);
  always_comb begin
    idx_o  = '0;
    none_o = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o  = IW'(i);
        none_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter import cafl_pkg::*; #(
  parameter int NBUF  = 16,
  parameter int NFIFO = 8,
  localparam int SELW = $clog2(NBUF + SEL_IND),
  localparam int BIW  = $clog2(NBUF),
  localparam int FIW  = $clog2(NFIFO)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 freeze_i,
  input  logic                 wr_en_i,
  input  logic [SELW-1:0]      wr_sel_i,
  input  logic [MASK_W-1:0]    wr_data_i,
  input  logic                 indiv_en_i,
  input  logic                 fifo_en_i,
  input  logic [NBUF*ID_W-1:0] flt_id_i,
  input  logic [NBUF-1:0]      flt_ide_i,
  input  logic [NBUF-1:0]      flt_rtr_i,
  input  logic                 frame_vld_i,
  input  logic [ID_W-1:0]      rx_id_i,
  input  logic                 rx_ide_i,
  input  logic                 rx_rtr_i,
  output logic                 res_vld_o,
  output logic [NBUF-1:0]      buf_hit_o,
  output logic [BIW-1:0]       buf_idx_o,
  output logic                 buf_none_o,
  output logic [NFIFO-1:0]     fifo_hit_o,
  output logic [FIW-1:0]       fifo_idx_o,
  output logic                 fifo_none_o
);
  localparam logic [NBUF-1:0] FIFO_RSV = {{(NBUF-NFIFO){1'b0}}, {NFIFO{1'b1}}};

  mask_t glb, la, lb;
  mask_t [NBUF-1:0] ind;
  logic [NBUF-1:0]  buf_raw, buf_c;
  logic [NFIFO-1:0] fifo_raw, fifo_c;
  logic [BIW-1:0]   buf_idx_c;
  logic [FIW-1:0]   fifo_idx_c;
  logic             buf_none_c, fifo_none_c;

  cafl_mask_regs #(.NBUF(NBUF), .SELW(SELW)) i_regs (
    .clk_i, .rst_ni, .freeze_i, .wr_en_i, .wr_sel_i,
    .wr_data_i(mask_t'(wr_data_i)),
    .glb_o(glb), .la_o(la), .lb_o(lb), .ind_o(ind)
  );

  for (genvar k = 0; k < NBUF; k++) begin : g_buf
    mask_t leg, msk;
    if (k == NBUF - 2)      begin : g_a assign leg = la;  end
    else if (k == NBUF - 1) begin : g_b assign leg = lb;  end
    else                    begin : g_g assign leg = glb; end
    assign msk = indiv_en_i ? ind[k] : leg;
    cafl_cmp i_cmp (
      .fifo_i(1'b0), .rx_id_i, .rx_ide_i, .rx_rtr_i,
      .flt_id_i(flt_id_i[k*ID_W +: ID_W]), .flt_ide_i(flt_ide_i[k]),
      .flt_rtr_i(flt_rtr_i[k]), .mask_i(msk), .hit_o(buf_raw[k])
    );
  end

  for (genvar e = 0; e < NFIFO; e++) begin : g_fifo
    mask_t leg, msk;
    if (e == NFIFO - 2)      begin : g_a assign leg = la;  end
    else if (e == NFIFO - 1) begin : g_b assign leg = lb;  end
    else                     begin : g_g assign leg = glb; end
    assign msk = indiv_en_i ? ind[e] : leg;
    cafl_cmp i_cmp (
      .fifo_i(1'b1), .rx_id_i, .rx_ide_i, .rx_rtr_i,
      .flt_id_i(flt_id_i[e*ID_W +: ID_W]), .flt_ide_i(flt_ide_i[e]),
      .flt_rtr_i(flt_rtr_i[e]), .mask_i(msk), .hit_o(fifo_raw[e])
    );
  end

  assign buf_c  = fifo_en_i ? (buf_raw & ~FIFO_RSV) : buf_raw;
  assign fifo_c = fifo_en_i ? fifo_raw : '0;

  cafl_lowest #(.N(NBUF))  i_buf_low  (.vec_i(buf_c),  .idx_o(buf_idx_c),  .none_o(buf_none_c));
  cafl_lowest #(.N(NFIFO)) i_fifo_low (.vec_i(fifo_c), .idx_o(fifo_idx_c), .none_o(fifo_none_c));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o   <= 1'b0;
      buf_hit_o   <= '0;
      buf_idx_o   <= '0;
      buf_none_o  <= 1'b1;
      fifo_hit_o  <= '0;
      fifo_idx_o  <= '0;
      fifo_none_o <= 1'b1;
    end else begin
      res_vld_o <= frame_vld_i;
      if (frame_vld_i) begin
        buf_hit_o   <= buf_c;
        buf_idx_o   <= buf_idx_c;
        buf_none_o  <= buf_none_c;
        fifo_hit_o  <= fifo_c;
        fifo_idx_o  <= fifo_idx_c;
        fifo_none_o <= fifo_none_c;
      end
    end
  end

  // R10
  vld_follows_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i |=> res_vld_o);
  // R10
  vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> !res_vld_o);
  // R9
  fifo_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && $past(fifo_en_i)) |-> (buf_hit_o[NFIFO-1:0] == '0));
  // R9
  fifo_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && !$past(fifo_en_i)) |-> (fifo_none_o && fifo_hit_o == '0));
  // R11
  buf_idx_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && !buf_none_o) |-> buf_hit_o[buf_idx_o]);
  // R11
  buf_idx_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && !buf_none_o) |-> ((buf_hit_o & ((NBUF'(1) << buf_idx_o) - NBUF'(1))) == '0));
endmodule

// File: tb/test_can_accept_filter.sv
module test_can_accept_filter;
  import cafl_pkg::*;
  localparam int CLK_P = 10;
  localparam int NBUF  = 16;
  localparam int NFIFO = 8;
  localparam int SELW  = $clog2(NBUF + SEL_IND);
  localparam int BIW   = $clog2(NBUF);
  localparam int FIW   = $clog2(NFIFO);
  localparam int WD    = 150000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic freeze = 1'b0, wr_en = 1'b0;
  logic [SELW-1:0] wr_sel = '0;
  logic [MASK_W-1:0] wr_data = '0;
  logic indiv = 1'b0, fifo_en = 1'b0;
  logic [NBUF*ID_W-1:0] flt_id = '0;
  logic [NBUF-1:0] flt_ide = '0, flt_rtr = '0;
  logic frame_vld = 1'b0;
  logic [ID_W-1:0] rx_id = '0;
  logic rx_ide = 1'b0, rx_rtr = 1'b0;
  logic res_vld, buf_none, fifo_none;
  logic [NBUF-1:0] buf_hit;
  logic [BIW-1:0] buf_idx;
  logic [NFIFO-1:0] fifo_hit;
  logic [FIW-1:0] fifo_idx;

  logic [ID_W-1:0] f_id [NBUF];
  logic [MASK_W-1:0] m_glb, m_a, m_b;
  logic [MASK_W-1:0] m_ind [NBUF];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  can_accept_filter #(.NBUF(NBUF), .NFIFO(NFIFO)) i_can_accept_filter (
    .clk_i(clk), .rst_ni, .freeze_i(freeze), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .indiv_en_i(indiv), .fifo_en_i(fifo_en),
    .flt_id_i(flt_id), .flt_ide_i(flt_ide), .flt_rtr_i(flt_rtr),
    .frame_vld_i(frame_vld), .rx_id_i(rx_id), .rx_ide_i(rx_ide), .rx_rtr_i(rx_rtr),
    .res_vld_o(res_vld), .buf_hit_o(buf_hit), .buf_idx_o(buf_idx), .buf_none_o(buf_none),
    .fifo_hit_o(fifo_hit), .fifo_idx_o(fifo_idx), .fifo_none_o(fifo_none)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [MASK_W-1:0] pick_mask(input int k, input bit fifo);
    int lim;
    lim = fifo ? NFIFO : NBUF;
    if (indiv) return m_ind[k];
    if (k == lim - 2) return m_a;
    if (k == lim - 1) return m_b;
    return m_glb;
  endfunction

  function automatic bit ent_hit(input int k, input bit fifo);
    logic [MASK_W-1:0] m;
    logic [ID_W-1:0] care;
    m = pick_mask(k, fifo);
    care = rx_ide ? '1 : {{11{1'b1}}, 18'h0};
    if (((rx_id ^ f_id[k]) & m[ID_W-1:0] & care) != '0) return 1'b0;
    if (!fifo) return rx_ide == flt_ide[k];
    if (m[ID_W] && rx_ide != flt_ide[k]) return 1'b0;
    if (m[ID_W+1] && rx_rtr != flt_rtr[k]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int lowest(input logic [NBUF-1:0] v);
    for (int i = 0; i < NBUF; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic load_flt();
    for (int k = 0; k < NBUF; k++) flt_id[k*ID_W +: ID_W] = f_id[k];
  endtask

  task automatic wr(input int sel, input logic [MASK_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = SELW'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (freeze) begin
      if (sel == 0) m_glb = d;
      else if (sel == 1) m_a = d;
      else if (sel == 2) m_b = d;
      else m_ind[sel-3] = d;
    end
  endtask

  task automatic frame(input logic [ID_W-1:0] id, input logic ide, input logic rtr,
                       input string rq);
    logic [NBUF-1:0] eb;
    logic [NFIFO-1:0] ef;
    @(negedge clk);
    rx_id = id; rx_ide = ide; rx_rtr = rtr; frame_vld = 1'b1;
    eb = '0; ef = '0;
    for (int k = 0; k < NBUF; k++)
      if (!(fifo_en && k < NFIFO)) eb[k] = ent_hit(k, 1'b0);
    for (int e = 0; e < NFIFO; e++)
      if (fifo_en) ef[e] = ent_hit(e, 1'b1);
    @(negedge clk);
    frame_vld = 1'b0;
    chk(res_vld == 1'b1, "R10", "valid", 32'(res_vld), 1);
    chk(buf_hit == eb, rq, "buf_hit", 32'(buf_hit), 32'(eb));
    chk(buf_none == (eb == '0), "R11", "buf_none", 32'(buf_none), 32'(eb == '0));
    if (eb != '0) chk(int'(buf_idx) == lowest(eb), "R11", "buf_idx", 32'(buf_idx), 32'(lowest(eb)));
    chk(fifo_hit == ef, rq, "fifo_hit", 32'(fifo_hit), 32'(ef));
    chk(fifo_none == (ef == '0), "R11", "fifo_none", 32'(fifo_none), 32'(ef == '0));
    if (ef != '0) chk(int'(fifo_idx) == lowest(NBUF'(ef)), "R11", "fifo_idx",
                      32'(fifo_idx), 32'(lowest(NBUF'(ef))));
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_glb = '1; m_a = '1; m_b = '1;
    for (int k = 0; k < NBUF; k++) begin
      m_ind[k] = '1;
      f_id[k] = ID_W'($urandom);
      flt_ide[k] = (k != 10);
      flt_rtr[k] = $urandom % 2;
    end
    load_flt();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(res_vld == 1'b0, "R10", "reset valid", 32'(res_vld), 0);
    chk(buf_none && fifo_none && buf_hit == '0, "R11", "reset none", 32'(buf_hit), 0);

    // R2 exact compare after reset
    frame(f_id[3], 1'b1, 1'b0, "R2");
    frame(f_id[3] ^ 29'h20, 1'b1, 1'b0, "R2");
    @(negedge clk);
    chk(res_vld == 1'b0, "R10", "valid single cycle", 32'(res_vld), 0);
    // R6 ordinary buffer ignores RTR, needs exact IDE
    frame(f_id[9], 1'b1, ~flt_rtr[9], "R6");
    frame(f_id[9], 1'b0, flt_rtr[9], "R6");
    // R8 write without freeze is ignored
    wr(SEL_GLB, '0);
    frame(f_id[2] ^ 29'h1, 1'b1, 1'b0, "R8");
    freeze = 1'b1;
    // R1 don't-care bits
    wr(SEL_GLB, ~31'h1);
    frame(f_id[2] ^ 29'h1, 1'b1, 1'b0, "R1");
    frame(f_id[2] ^ 29'h2, 1'b1, 1'b0, "R1");
    // R3 dedicated masks for the last two buffers
    wr(SEL_LA, ~31'h100);
    frame(f_id[14] ^ 29'h100, 1'b1, 1'b0, "R3");
    frame(f_id[15] ^ 29'h1, 1'b1, 1'b0, "R3");
    wr(SEL_GLB, '0);
    frame(f_id[15], 1'b1, 1'b0, "R3");
    // R4 individual masks
    wr(SEL_IND + 5, '0);
    indiv = 1'b1;
    frame(29'h1ABCDE, 1'b1, 1'b0, "R4");
    frame(f_id[14] ^ 29'h100, 1'b1, 1'b0, "R4");
    // R7 standard frame ignores low identifier bits
    indiv = 1'b0;
    wr(SEL_GLB, '1);
    frame(f_id[10] ^ 29'h3FFFF, 1'b0, 1'b0, "R7");
    frame(f_id[10] ^ 29'h40000, 1'b0, 1'b0, "R7");
    // R5 R6 R9 FIFO mode
    fifo_en = 1'b1;
    wr(SEL_LA, {2'b00, 29'h1FFFFFFF});
    frame(f_id[6], ~flt_ide[6], ~flt_rtr[6], "R5");
    frame(f_id[7], ~flt_ide[7], flt_rtr[7], "R6");
    wr(SEL_LB, {2'b01, 29'h1FFFFFFF});
    frame(f_id[7], flt_ide[7], ~flt_rtr[7], "R5");
    frame(f_id[3], 1'b1, 1'b0, "R9");
    wr(SEL_GLB, '0);
    frame(f_id[0], 1'b1, 1'b0, "R9");
    indiv = 1'b1;
    frame(f_id[4], 1'b1, 1'b0, "R4");
    fifo_en = 1'b0;
    frame(f_id[4], 1'b1, 1'b0, "R9");

    // R1 constrained random
    for (int k = 0; k < NBUF; k++) flt_ide[k] = $urandom % 2;
    for (int it = 0; it < 600; it++) begin
      int j;
      logic [ID_W-1:0] id;
      if ($urandom % 4 == 0) begin
        freeze = ($urandom % 3 != 0);
        case ($urandom % 3)
          0: wr($urandom % (NBUF + 3), MASK_W'($urandom & $urandom));
          1: wr($urandom % (NBUF + 3), '1 ^ (MASK_W'(1) << ($urandom % MASK_W)));
          default: wr($urandom % (NBUF + 3), MASK_W'($urandom));
        endcase
      end
      if ($urandom % 8 == 0) indiv = $urandom % 2;
      if ($urandom % 8 == 0) fifo_en = $urandom % 2;
      j = $urandom % NBUF;
      id = f_id[j];
      if ($urandom % 3 == 0) id = id ^ (ID_W'(1) << ($urandom % ID_W));
      frame(id, ($urandom % 4 == 0) ? ~flt_ide[j] : flt_ide[j], 1'($urandom), "R1");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule